// File: doc/BRIEF.md
# Soft-Stepping Stereo Volume Attenuator

This block scales a stereo stream of signed PCM samples by a per-channel attenuation chosen in half-decibel increments, from unity gain down to -63.5 dB, with silence as a further setting. The host loads a target for each channel, or loads both at once with a master write. The block then walks each channel's applied level toward its target rather than jumping, so a gain change produces no audible click.

The walk advances only when a sample arrives: one level per sample, or one level per two samples when the slow rate is selected. With ramping disabled, the applied level follows the target in the next cycle. A settled output tells the host when both channels have reached their targets, for example before it cuts the clock or changes the sample rate.

Top module: `vss_volume`

## Requirements
- R1: A level is an 8-bit value: 0 to 127 mean an attenuation of level x 0.5 dB, and 128 means silence. A target write with its mute bit set loads 128, otherwise it loads the 7-bit code. After reset both targets and both applied levels are 128, settled is 1, out_valid is 0 and both sample outputs are 0.
- R2: A pulse on tgt_left_wr loads only the left target and a pulse on tgt_right_wr loads only the right target.
- R3: A pulse on master_wr loads both targets with the same value, and takes priority over a channel write in the same cycle.
- R4: With ramp_en high and ramp_slow low, each cycle with in_valid high moves each applied level one step toward its target. Without in_valid, the levels do not change.
- R5: With ramp_slow high, a step is taken only on every second in_valid cycle. The two-sample count advances only on in_valid and restarts while ramp_slow is low, so the first sample after selecting the slow rate takes no step.
- R6: With ramp_en low, each applied level equals its target from the cycle after the target was loaded, whether or not samples arrive.
- R7: settled is high exactly when both applied levels equal their targets.
- R8: One cycle after in_valid, out_valid is high and each output carries round(sample x M[L mod 12] / 2^(15 + L div 12)), with rounding half-up and saturation to the sample width. Here L is the level held before that cycle's step and M[k] = round(32768 x 10^(-k/40)). The outputs hold their value between samples.
- R9: A sample taken while the applied level is 128 produces an output of 0.
- R10: A target written in the same cycle as in_valid does not steer that cycle's step. The step uses the target held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample strobe for both channels |
| in_left | input | SMP_W | Left sample, signed |
| in_right | input | SMP_W | Right sample, signed |
| tgt_left_wr | input | 1 | Load left target |
| tgt_left_code | input | 7 | Left attenuation code |
| tgt_left_mute | input | 1 | Left silence select |
| tgt_right_wr | input | 1 | Load right target |
| tgt_right_code | input | 7 | Right attenuation code |
| tgt_right_mute | input | 1 | Right silence select |
| master_wr | input | 1 | Load both targets |
| master_code | input | 7 | Shared attenuation code |
| master_mute | input | 1 | Shared silence select |
| ramp_en | input | 1 | Step gradually instead of jumping |
| ramp_slow | input | 1 | One step per two samples |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | SMP_W | Scaled left sample |
| out_right | output | SMP_W | Scaled right sample |
| lvl_left | output | 8 | Applied left level |
| lvl_right | output | 8 | Applied right level |
| settled | output | 1 | Both levels at target |

## Verification
Two functions can fall in the same cycle. A target load can coincide with a sample strobe, and a master write can coincide with a channel write. The bench drives a master write together with in_valid while the level already equals the old target. It expects no movement on that sample and a step only on the following one. It also drives master_wr and tgt_left_wr together with different codes and expects both levels to reach the master value.

// File: rtl/vss_pkg.sv
package vss_pkg;

    localparam int NCH       = 2;
    localparam int CODE_W    = 7;
    localparam int LVL_W     = CODE_W + 1;
    localparam int MANT_W    = 17;
    localparam int MANT_FRAC = 15;
    localparam int OCT_STEPS = 12;
    localparam logic [LVL_W-1:0] LVL_SILENT = LVL_W'(1 << CODE_W);

    typedef struct packed {
        logic [NCH-1:0][LVL_W-1:0] tgt;
        logic                      div;
        logic                      ovalid;
    } vss_ctl_t;

    // Q15 gain of each half-decibel step within one 6 dB octave
    function automatic logic [MANT_W-1:0] oct_mant(input logic [3:0] k);
        case (k)
            4'd0:    oct_mant = 17'd32768;
            4'd1:    oct_mant = 17'd30935;
            4'd2:    oct_mant = 17'd29205;
            4'd3:    oct_mant = 17'd27571;
            4'd4:    oct_mant = 17'd26029;
            4'd5:    oct_mant = 17'd24573;
            4'd6:    oct_mant = 17'd23198;
            4'd7:    oct_mant = 17'd21900;
            4'd8:    oct_mant = 17'd20675;
            4'd9:    oct_mant = 17'd19519;
            4'd10:   oct_mant = 17'd18427;
            4'd11:   oct_mant = 17'd17396;
            default: oct_mant = 17'd0;
        endcase
    endfunction

    function automatic logic [LVL_W-1:0] code_to_lvl(input logic [CODE_W-1:0] code,
                                                     input logic              mute);
        code_to_lvl = mute ? LVL_SILENT : {1'b0, code};
    endfunction

endpackage

// File: rtl/vss_ramp.sv
module vss_ramp
    import vss_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ramp_en_i,
    input  logic             valid_i,
    input  logic             step_ok_i,
    input  logic [LVL_W-1:0] tgt_i,
    output logic [LVL_W-1:0] lvl_o
);

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
    } ramp_st_t;

    ramp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ramp_en_i) begin
            st_d.lvl = tgt_i;
        end else if (valid_i && step_ok_i) begin
            if (st_q.lvl < tgt_i) begin
                st_d.lvl = st_q.lvl + LVL_W'(1);
            end else if (st_q.lvl > tgt_i) begin
                st_d.lvl = st_q.lvl - LVL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= LVL_SILENT;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;

    AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lvl <= LVL_SILENT); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en_i && !valid_i) |=> $stable(st_q.lvl)); // R4
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_en_i |=> (st_q.lvl == $past(st_q.lvl) ||
                       st_q.lvl == $past(st_q.lvl) + LVL_W'(1) ||
                       st_q.lvl + LVL_W'(1) == $past(st_q.lvl))); // R4
    AST_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        !ramp_en_i |=> st_q.lvl == $past(tgt_i)); // R6

endmodule

// File: rtl/vss_gain.sv
module vss_gain
    import vss_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_i,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic [LVL_W-1:0]        lvl_i,
    output logic signed [SMP_W-1:0] smp_o
);

    localparam int PW = SMP_W + MANT_W + 1;
    localparam logic signed [PW-1:0] MAXV = PW'((2 ** (SMP_W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    typedef struct packed {
        logic signed [SMP_W-1:0] smp;
    } gain_st_t;

    gain_st_t st_d, st_q;

    logic [3:0]              idx;
    logic [5:0]              sh;
    logic signed [PW-1:0]    opa, opb, prod, half, biased, shifted;
    logic signed [SMP_W-1:0] scaled;

    always_comb begin
        idx     = 4'(lvl_i % LVL_W'(OCT_STEPS));
        sh      = 6'(MANT_FRAC) + 6'(lvl_i / LVL_W'(OCT_STEPS));
        opa     = PW'(smp_i);
        opb     = $signed(PW'(oct_mant(idx)));
        prod    = opa * opb;
        half    = '0;
        half[sh - 6'd1] = 1'b1;
        biased  = prod + half;
        shifted = biased >>> sh;
        if (lvl_i >= LVL_SILENT) begin
            scaled = '0;
        end else if (shifted > MAXV) begin
            scaled = MAXV[SMP_W-1:0];
        end else if (shifted < MINV) begin
            scaled = MINV[SMP_W-1:0];
        end else begin
            scaled = shifted[SMP_W-1:0];
        end

        st_d = st_q;
        if (valid_i) begin
            st_d.smp = scaled;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.smp <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp_o = st_q.smp;

    AST_SILENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && lvl_i == LVL_SILENT) |=> smp_o == '0); // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(smp_o)); // R8
    AST_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !smp_i[SMP_W-1]) |=> (smp_o <= smp_i_d1)); // R8

    logic signed [SMP_W-1:0] smp_i_d1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_i_d1 <= '0;
        end else begin
            smp_i_d1 <= smp_i;
        end
    end

endmodule

// File: rtl/vss_volume.sv
module vss_volume
    import vss_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [SMP_W-1:0] in_left,
    input  logic signed [SMP_W-1:0] in_right,
    input  logic                    tgt_left_wr,
    input  logic [CODE_W-1:0]       tgt_left_code,
    input  logic                    tgt_left_mute,
    input  logic                    tgt_right_wr,
    input  logic [CODE_W-1:0]       tgt_right_code,
    input  logic                    tgt_right_mute,
    input  logic                    master_wr,
    input  logic [CODE_W-1:0]       master_code,
    input  logic                    master_mute,
    input  logic                    ramp_en,
    input  logic                    ramp_slow,
    output logic                    out_valid,
    output logic signed [SMP_W-1:0] out_left,
    output logic signed [SMP_W-1:0] out_right,
    output logic [LVL_W-1:0]        lvl_left,
    output logic [LVL_W-1:0]        lvl_right,
    output logic                    settled
);

    vss_ctl_t ctl_d, ctl_q;

    logic                    ch_wr    [NCH];
    logic [LVL_W-1:0]        ch_lvl_w [NCH];
    logic signed [SMP_W-1:0] smp_in   [NCH];
    logic signed [SMP_W-1:0] smp_out  [NCH];
    logic [LVL_W-1:0]        lvl      [NCH];
    logic                    step_ok;

    assign ch_wr[0]    = tgt_left_wr;
    assign ch_wr[1]    = tgt_right_wr;
    assign ch_lvl_w[0] = code_to_lvl(tgt_left_code, tgt_left_mute);
    assign ch_lvl_w[1] = code_to_lvl(tgt_right_code, tgt_right_mute);
    assign smp_in[0]   = in_left;
    assign smp_in[1]   = in_right;

    always_comb begin
        ctl_d = ctl_q;
        for (int c = 0; c < NCH; c++) begin
            if (master_wr) begin
                ctl_d.tgt[c] = code_to_lvl(master_code, master_mute);
            end else if (ch_wr[c]) begin
                ctl_d.tgt[c] = ch_lvl_w[c];
            end
        end
        if (!ramp_slow) begin
            ctl_d.div = 1'b0;
        end else if (in_valid) begin
            ctl_d.div = ~ctl_q.div;
        end
        ctl_d.ovalid = in_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.tgt    <= {NCH{LVL_SILENT}};
            ctl_q.div    <= 1'b0;
            ctl_q.ovalid <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign step_ok = !ramp_slow || ctl_q.div;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        vss_ramp u_ramp (
            .clk       (clk),
            .rst_n     (rst_n),
            .ramp_en_i (ramp_en),
            .valid_i   (in_valid),
            .step_ok_i (step_ok),
            .tgt_i     (ctl_q.tgt[c]),
            .lvl_o     (lvl[c])
        );
        vss_gain #(.SMP_W(SMP_W)) u_gain (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (in_valid),
            .smp_i   (smp_in[c]),
            .lvl_i   (lvl[c]),
            .smp_o   (smp_out[c])
        );
    end

    assign out_valid = ctl_q.ovalid;
    assign out_left  = smp_out[0];
    assign out_right = smp_out[1];
    assign lvl_left  = lvl[0];
    assign lvl_right = lvl[1];

    always_comb begin
        settled = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            if (lvl[c] != ctl_q.tgt[c]) begin
                settled = 1'b0;
            end
        end
    end

    AST_MASTER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        master_wr |=> ctl_q.tgt[0] == ctl_q.tgt[1]); // R3
    AST_OUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_SETTLED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !master_wr && !tgt_left_wr && !tgt_right_wr) |=> settled); // R7
    AST_SLOW_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en && ramp_slow && in_valid && !ctl_q.div) |=> $stable(lvl_left)); // R5

endmodule

// File: tb/vss_volume_tb.sv
`timescale 1ns/1ps
module vss_volume_tb_top;

    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic                in_valid = 0;
    logic signed [W-1:0] in_left = '0, in_right = '0;
    logic                tgt_left_wr = 0, tgt_left_mute = 0;
    logic [6:0]          tgt_left_code = '0;
    logic                tgt_right_wr = 0, tgt_right_mute = 0;
    logic [6:0]          tgt_right_code = '0;
    logic                master_wr = 0, master_mute = 0;
    logic [6:0]          master_code = '0;
    logic                ramp_en = 0, ramp_slow = 0;
    logic                out_valid;
    logic signed [W-1:0] out_left, out_right;
    logic [7:0]          lvl_left, lvl_right;
    logic                settled;

    vss_volume #(.SMP_W(W)) dut_i (.*);

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model(input longint smp, input int lv);
        int k, s, m;
        longint p, r;
        if (lv >= 128) return 0;
        k = lv % 12;
        s = lv / 12;
        m = $rtoi(32768.0 * $pow(10.0, -k / 40.0) + 0.5);
        p = smp * m;
        r = (p + (longint'(1) <<< (14 + s))) >>> (15 + s);
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_master(input int lv);
        master_wr = 1; master_mute = (lv >= 128); master_code = 7'(lv);
        cyc(1);
        master_wr = 0;
    endtask

    task automatic wr_left(input int lv);
        tgt_left_wr = 1; tgt_left_mute = (lv >= 128); tgt_left_code = 7'(lv);
        cyc(1);
        tgt_left_wr = 0;
    endtask

    task automatic wr_right(input int lv);
        tgt_right_wr = 1; tgt_right_mute = (lv >= 128); tgt_right_code = 7'(lv);
        cyc(1);
        tgt_right_wr = 0;
    endtask

    task automatic pulse(input logic signed [W-1:0] l, input logic signed [W-1:0] r);
        in_valid = 1; in_left = l; in_right = r;
        cyc(1);
        in_valid = 0;
    endtask

    typedef struct packed {
        logic [7:0]          lv;
        logic signed [W-1:0] smp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'd0,   16'sh7FFF}, '{8'd0,   -16'sd32768}, '{8'd1,   16'sd12345},
        '{8'd5,   -16'sd1000}, '{8'd11,  16'sd30000}, '{8'd12,  -16'sd32768},
        '{8'd13,  16'sd777},  '{8'd23,  -16'sd12345}, '{8'd64,  16'sd32767},
        '{8'd100, -16'sd20000}, '{8'd127, 16'sd32767}, '{8'd127, -16'sd32768},
        '{8'd128, 16'sd5000}, '{8'd6,   16'sd1}
    };

    initial begin
        cyc(2);
        // R1 reset state
        chk("R1 lvl_left reset", lvl_left, 128);
        chk("R1 lvl_right reset", lvl_right, 128);
        chk("R1 settled reset", settled, 1);
        chk("R1 out_valid reset", out_valid, 0);
        chk("R1 out_left reset", out_left, 0);
        rst_n = 1;
        cyc(2);

        // R8 R9 table walk, jump mode, per-channel writes
        ramp_en = 0;
        for (int i = 0; i < NV; i++) begin
            wr_left(VECS[i].lv);
            wr_right(VECS[i].lv);
            cyc(1);
            pulse(VECS[i].smp, ~VECS[i].smp);
            chk("R8 out_valid", out_valid, 1);
            chk("R8 out_left scaled", out_left, model(VECS[i].smp, VECS[i].lv));
            chk("R8 out_right scaled", out_right, model(~VECS[i].smp, VECS[i].lv));
        end

        // R6 jump without samples
        wr_master(10);
        cyc(1);
        chk("R6 jump left", lvl_left, 10);
        chk("R6 jump right", lvl_right, 10);

        // R4 fast ramp, R7 settled
        ramp_en = 1;
        wr_master(13);
        chk("R7 not settled", settled, 0);
        cyc(3);
        chk("R4 idle no step", lvl_left, 10);
        pulse(16'sd10000, -16'sd10000);
        chk("R4 first step", lvl_left, 11);
        chk("R8 pre-step level used", out_left, model(10000, 10));
        pulse(16'sd10000, -16'sd10000);
        chk("R7 still ramping", settled, 0);
        pulse(16'sd10000, -16'sd10000);
        chk("R4 reached target", lvl_right, 13);
        chk("R7 settled after ramp", settled, 1);

        // R5 slow ramp
        ramp_slow = 1;
        wr_master(10);
        pulse(16'sd1, 16'sd1);
        chk("R5 first sample no step", lvl_left, 13);
        pulse(16'sd1, 16'sd1);
        chk("R5 second sample steps", lvl_left, 12);
        pulse(16'sd1, 16'sd1);
        chk("R5 third sample no step", lvl_left, 12);
        cyc(2);
        pulse(16'sd1, 16'sd1);
        chk("R5 fourth sample steps", lvl_left, 11);
        ramp_slow = 0;

        // R2 left-only write
        wr_left(20);
        ramp_en = 0;
        cyc(1);
        chk("R2 left loaded", lvl_left, 20);
        chk("R2 right untouched", lvl_right, 10);

        // R3 master beats channel write
        master_wr = 1; master_mute = 0; master_code = 7'd30;
        tgt_left_wr = 1; tgt_left_mute = 0; tgt_left_code = 7'd40;
        cyc(1);
        master_wr = 0; tgt_left_wr = 0;
        cyc(1);
        chk("R3 master wins left", lvl_left, 30);
        chk("R3 master sets right", lvl_right, 30);

        // R10 write coinciding with sample
        ramp_en = 1;
        master_wr = 1; master_mute = 0; master_code = 7'd40;
        in_valid = 1; in_left = 16'sd5; in_right = 16'sd5;
        cyc(1);
        master_wr = 0; in_valid = 0;
        chk("R10 old target steers step", lvl_left, 30);
        pulse(16'sd5, 16'sd5);
        chk("R10 new target next sample", lvl_left, 31);

        // R9 ramp into silence
        ramp_en = 0;
        wr_left(127);
        cyc(1);
        ramp_en = 1;
        wr_left(128);
        pulse(16'sd30000, 16'sd30000);
        chk("R9 step into silence", lvl_left, 128);
        chk("R9 last audible sample", out_left, model(30000, 127));
        pulse(16'sd30000, 16'sd30000);
        chk("R9 silent output", out_left, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule